// File: doc/BRIEF.md
# Compare-and-Exchange Execution Unit

This unit carries out one atomic compare-and-exchange step for a processor datapath. It works on 8-, 16- or 32-bit operands. The destination operand is either a register value supplied on a port or a word fetched over a small memory port. The unit compares the low bits of the accumulator with the destination. On a match it writes the source value into the destination and leaves the accumulator alone. On a mismatch it leaves the destination alone and copies the destination value into the accumulator.

In every completed case the unit produces arithmetic flags as for `accumulator - destination`, together with a cycle cost. A fault on either memory access ends the operation early with an abort. Address generation and decode stay outside the unit.

The controller is one state machine. Its states and transitions are:
- **IDLE**: waits for `start_i`. A register operation goes to EVAL. A memory operation goes to READ.
- **READ**: holds a read request until acknowledge. A fault goes to FIN as an abort. A clean read goes to EVAL.
- **EVAL**: compares and computes the flags. A memory match goes to WRITE. Every other case goes to FIN.
- **WRITE**: holds a write request until acknowledge. A fault goes to FIN as an abort. A clean write goes to FIN.
- **FIN**: raises `done_o` for one cycle, then returns to IDLE.

Top module: `cmpxchg_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_req_o` are all low.
- R2: When the operand-width parts of the accumulator and destination are equal, the destination receives the source. In register mode `dst_wr_o`=1, and `dst_o` holds the upper bits of `rdst_i` with the source's low bits. In memory mode one write carries the source zero-extended from the width. In both modes `acc_wr_o`=0.
- R3: When they differ, `acc_wr_o`=1 and `acc_o` holds the upper accumulator bits with the destination's low bits. There is no destination write of either kind.
- R4: `flags_o` bits are {5:OF, 4:SF, 3:ZF, 2:AF, 1:PF, 0:CF}, computed for old accumulator minus destination at the operand width:
  - CF is the borrow.
  - ZF is set when the result is zero.
  - SF is the result's top bit.
  - OF is signed overflow.
  - PF is even parity of the result's low byte.
  - AF is the borrow out of bit 3.
  - On success `flags_wr_o`=1.
- R5: `size_i` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Bits above the width never affect the compare or the flags.
- R6: A faulting read ends with `abort_o`=1 and with no accumulator write, destination write, memory write or flag write.
- R7: A faulting write ends with `abort_o`=1, `flags_wr_o`=0 and `acc_wr_o`=0.
- R8: `cycles_o` is 6 for a register destination and 10 for a memory destination on success, and 0 on abort.
- R9: `done_o` is high for exactly one clock per operation. `abort_o` and all result outputs are valid in that cycle.
- R10: `start_i` is ignored while `busy_o` is high, and the running operation's result is unaffected.
- R11: `mem_req_o` stays high with a stable `mem_we_o` until `mem_ack_i`. `mem_we_o` is 0 for the read and 1 for the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin an operation (sampled in IDLE) |
| size_i | input | 2 | Operand width code |
| mem_mode_i | input | 1 | 1 = memory destination, 0 = register destination |
| acc_i | input | 32 | Accumulator value |
| src_i | input | 32 | Source register value |
| rdst_i | input | 32 | Register destination value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write request |
| mem_size_o | output | 2 | Width code for the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| mem_fault_i | input | 1 | Fault, valid with ack |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | Operation aborted |
| acc_wr_o | output | 1 | Accumulator write enable |
| acc_o | output | 32 | New accumulator |
| dst_wr_o | output | 1 | Register destination write enable |
| dst_o | output | 32 | New register destination |
| flags_wr_o | output | 1 | Flag write enable |
| flags_o | output | 6 | Flags {OF,SF,ZF,AF,PF,CF} |
| cycles_o | output | 4 | Cycle cost |

## Verification
The bench targets byte and halfword operands whose upper bits disagree while the low bits match. A design that compares the full word would wrongly take the mismatch path there. It also uses subtractions that set overflow, auxiliary borrow and parity. A flag unit that tests bit 31 or the wrong nibble would report wrong flags.

Read and write faults are injected separately. A design that updates flags or registers before the fault is known would be caught. A second start is pulsed while a memory read is pending. A unit that re-latches its operands at that point would return the wrong accumulator.

// File: rtl/cmpxchg_pkg.sv
package cmpxchg_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        S_IDLE, S_READ, S_EVAL, S_WRITE, S_FIN
    } state_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } flags_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    width_mask = DATA_W'(32'h0000_00FF);
            2'd1:    width_mask = DATA_W'(32'h0000_FFFF);
            default: width_mask = '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge_low(input logic [DATA_W-1:0] base,
                                                    input logic [DATA_W-1:0] low,
                                                    input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        m = width_mask(sz);
        merge_low = (base & ~m) | (low & m);
    endfunction
endpackage

// File: rtl/cmpxchg_lane.sv
module cmpxchg_lane
    import cmpxchg_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] acc_m,
    output logic [DATA_W-1:0] dst_m,
    output logic              equal
);
    logic [DATA_W-1:0] mask;
    always_comb begin
        mask  = width_mask(size);
        acc_m = acc & mask;
        dst_m = dst & mask;
        equal = (acc_m == dst_m);
    end
endmodule

// File: rtl/cmpxchg_flags.sv
module cmpxchg_flags
    import cmpxchg_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output flags_t            flags
);
    localparam int TOP8  = 7;
    localparam int TOP16 = 15;
    localparam int TOP32 = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] res;
    int unsigned       top;

    always_comb begin
        case (size)
            2'd0:    top = TOP8;
            2'd1:    top = TOP16;
            default: top = TOP32;
        endcase
        diff       = a - b;
        res        = diff & width_mask(size);
        flags.cf_f = (a < b);
        flags.zf_f = (res == '0);
        flags.sf_f = res[top];
        flags.of_f = (a[top] ^ b[top]) & (res[top] ^ a[top]);
        flags.pf_f = ~^res[7:0];
        flags.af_f = a[4] ^ b[4] ^ res[4];
    end
endmodule

// File: rtl/cmpxchg_unit.sv
module cmpxchg_unit
    import cmpxchg_pkg::*;
#(
    parameter int REG_COST = 6,
    parameter int MEM_COST = 10,
    localparam int COST_W  = $clog2(MEM_COST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic              mem_mode_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] rdst_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_fault_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              abort_o,
    output logic              acc_wr_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              dst_wr_o,
    output logic [DATA_W-1:0] dst_o,
    output logic              flags_wr_o,
    output logic [5:0]        flags_o,
    output logic [COST_W-1:0] cycles_o
);
    state_e            state_q, state_d;
    logic              mode_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] acc_q, src_q, rdst_q, dst_q;
    logic [DATA_W-1:0] acc_m, dst_m;
    logic              match;
    flags_t            flags_c, flags_q;

    cmpxchg_lane u_lane (
        .size(size_q), .acc(acc_q), .dst(dst_q),
        .acc_m(acc_m), .dst_m(dst_m), .equal(match)
    );

    cmpxchg_flags u_flags (
        .size(size_q), .a(acc_m), .b(dst_m), .flags(flags_c)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = mem_mode_i ? S_READ : S_EVAL;
            S_READ:  if (mem_ack_i) state_d = mem_fault_i ? S_FIN : S_EVAL;
            S_EVAL:  state_d = (match && mode_q) ? S_WRITE : S_FIN;
            S_WRITE: if (mem_ack_i) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            size_q     <= '0;
            acc_q      <= '0;
            src_q      <= '0;
            rdst_q     <= '0;
            dst_q      <= '0;
            flags_q    <= '0;
            abort_o    <= 1'b0;
            acc_wr_o   <= 1'b0;
            acc_o      <= '0;
            dst_wr_o   <= 1'b0;
            dst_o      <= '0;
            flags_wr_o <= 1'b0;
            cycles_o   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    mode_q     <= mem_mode_i;
                    size_q     <= size_i;
                    acc_q      <= acc_i;
                    src_q      <= src_i;
                    rdst_q     <= rdst_i;
                    dst_q      <= rdst_i;
                    abort_o    <= 1'b0;
                    acc_wr_o   <= 1'b0;
                    dst_wr_o   <= 1'b0;
                    flags_wr_o <= 1'b0;
                    cycles_o   <= '0;
                end
                S_READ: if (mem_ack_i) begin
                    if (mem_fault_i) abort_o <= 1'b1;
                    else             dst_q   <= mem_rdata_i;
                end
                S_EVAL: begin
                    flags_q <= flags_c;
                    acc_o   <= merge_low(acc_q, dst_q, size_q);
                    dst_o   <= merge_low(rdst_q, src_q, size_q);
                    if (!(match && mode_q)) begin
                        acc_wr_o   <= !match;
                        dst_wr_o   <= match && !mode_q;
                        flags_wr_o <= 1'b1;
                        cycles_o   <= mode_q ? COST_W'(MEM_COST) : COST_W'(REG_COST);
                    end
                end
                S_WRITE: if (mem_ack_i) begin
                    if (mem_fault_i) begin
                        abort_o <= 1'b1;
                    end else begin
                        flags_wr_o <= 1'b1;
                        cycles_o   <= COST_W'(MEM_COST);
                    end
                end
                S_FIN: ;
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != S_IDLE);
    assign done_o      = (state_q == S_FIN);
    assign mem_req_o   = (state_q == S_READ) || (state_q == S_WRITE);
    assign mem_we_o    = (state_q == S_WRITE);
    assign mem_size_o  = size_q;
    assign mem_wdata_o = src_q & width_mask(size_q);
    assign flags_o     = flags_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && abort_o) |-> (!flags_wr_o && !acc_wr_o && !dst_wr_o && cycles_o == '0));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o)));

    // R4
    flags_on_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !abort_o) |-> flags_wr_o);

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(acc_wr_o && dst_wr_o));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/cmpxchg_unit_tb_top.sv
module cmpxchg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        mem_mode_i = 1'b0;
    logic [31:0] acc_i = '0, src_i = '0, rdst_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [1:0]  mem_size_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_fault_i = 1'b0;
    logic        busy_o, done_o, abort_o, acc_wr_o, dst_wr_o, flags_wr_o;
    logic [31:0] acc_o, dst_o;
    logic [5:0]  flags_o;
    logic [3:0]  cycles_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmpxchg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .mem_mode_i(mem_mode_i), .acc_i(acc_i), .src_i(src_i), .rdst_i(rdst_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .mem_fault_i(mem_fault_i), .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o),
        .acc_wr_o(acc_wr_o), .acc_o(acc_o), .dst_wr_o(dst_wr_o), .dst_o(dst_o),
        .flags_wr_o(flags_wr_o), .flags_o(flags_o), .cycles_o(cycles_o)
    );

    // {mode, size, acc, src, rdst, mem data}
    localparam int NV = 10;
    localparam logic [130:0] VEC [NV] = '{
        {1'b0, 2'd2, 32'h1234_5678, 32'hCAFE_F00D, 32'h1234_5678, 32'h0},
        {1'b0, 2'd2, 32'h0000_0001, 32'h0000_0005, 32'h0000_0002, 32'h0},
        {1'b0, 2'd0, 32'hAAAA_0055, 32'h1111_22EE, 32'hBBBB_CC55, 32'h0},
        {1'b0, 2'd0, 32'h0000_0080, 32'h0000_0007, 32'h0000_0001, 32'h0},
        {1'b0, 2'd1, 32'hFFFF_7FFF, 32'h0000_0009, 32'h0000_FFFF, 32'h0},
        {1'b1, 2'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h0, 32'hDEAD_BEEF},
        {1'b1, 2'd1, 32'h0000_1234, 32'h0000_5678, 32'h0, 32'hFFFF_1230},
        {1'b1, 2'd0, 32'h0000_0011, 32'h7777_7799, 32'h0, 32'h0000_EE11},
        {1'b1, 2'd3, 32'h0000_0000, 32'h0000_0001, 32'h0, 32'h0000_0000},
        {1'b0, 2'd1, 32'h0001_0010, 32'h0000_0003, 32'h0002_0010, 32'h0}
    };

    // captured results
    logic        r_done, r_abort, r_accwr, r_dstwr, r_flwr, r_wrote, r_pulse_ok;
    logic [31:0] r_acc, r_dst, r_wdata;
    logic [5:0]  r_flags;
    logic [3:0]  r_cyc;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [5:0] ref_flags(input logic [1:0] sz, input logic [31:0] a0, input logic [31:0] b0);
        logic [31:0] a, b, r;
        int top;
        logic cf, zf, sf, of_, pf, af;
        a = a0 & msk(sz);
        b = b0 & msk(sz);
        r = (a - b) & msk(sz);
        top = (sz == 2'd0) ? 7 : (sz == 2'd1) ? 15 : 31;
        cf = (a < b);
        zf = (r == 0);
        sf = r[top];
        of_ = (a[top] != b[top]) && (r[top] != a[top]);
        pf = ~^r[7:0];
        af = ((a & 32'hF) < (b & 32'hF));
        return {of_, sf, zf, af, pf, cf};
    endfunction

    task automatic run_op(input logic mode, input logic [1:0] sz, input logic [31:0] acc,
                          input logic [31:0] src, input logic [31:0] rdst, input logic [31:0] mdata,
                          input bit rd_fault, input bit wr_fault, input bit poke);
        r_done = 0; r_wrote = 0; r_pulse_ok = 1;
        @(negedge clk);
        start_i = 1; mem_mode_i = mode; size_i = sz; acc_i = acc; src_i = src; rdst_i = rdst;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 40; i++) begin
            if (poke && i == 0) begin
                start_i = 1; acc_i = ~acc; mem_mode_i = 0;
            end else begin
                start_i = 0;
            end
            if (done_o) begin
                r_done = 1; r_abort = abort_o; r_accwr = acc_wr_o; r_acc = acc_o;
                r_dstwr = dst_wr_o; r_dst = dst_o; r_flwr = flags_wr_o; r_flags = flags_o;
                r_cyc = cycles_o;
                mem_ack_i = 0;
                @(negedge clk);
                r_pulse_ok = !done_o;
                break;
            end
            if (mem_ack_i) begin
                mem_ack_i = 0; mem_fault_i = 0;
            end else if (mem_req_o && i >= 2) begin
                mem_ack_i = 1;
                mem_rdata_i = mdata;
                mem_fault_i = mem_we_o ? wr_fault : rd_fault;
                if (mem_we_o && !wr_fault) begin
                    r_wrote = 1; r_wdata = mem_wdata_o;
                end
            end
            @(negedge clk);
        end
        start_i = 0; mem_ack_i = 0; mem_fault_i = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !mem_req_o, "R1", {29'b0, busy_o, done_o, mem_req_o}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R1", {29'b0, busy_o, done_o, mem_req_o}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic m; logic [1:0] sz; logic [31:0] a, s, rd, md, dv, msk_v; bit eq;
            {m, sz, a, s, rd, md} = VEC[v];
            run_op(m, sz, a, s, rd, md, 0, 0, 0);
            dv = m ? md : rd;
            msk_v = msk(sz);
            eq = ((a & msk_v) == (dv & msk_v));
            chk(r_done && !r_abort, "R9", {31'b0, r_abort}, 32'h0);
            chk(r_pulse_ok, "R9", 32'(r_pulse_ok), 32'h1);
            chk(r_flwr && r_flags == ref_flags(sz, a, dv), "R4", 32'(r_flags), 32'(ref_flags(sz, a, dv)));
            chk(r_cyc == (m ? 4'd10 : 4'd6), "R8", 32'(r_cyc), m ? 32'd10 : 32'd6);
            if (eq) begin
                // R2 and R5: match judged on low bits only
                chk(!r_accwr, "R2", 32'(r_accwr), 32'h0);
                if (m) begin
                    chk(r_wrote && r_wdata == (s & msk_v), "R2", r_wdata, s & msk_v);
                    chk(!r_dstwr, "R2", 32'(r_dstwr), 32'h0);
                end else begin
                    chk(r_dstwr && r_dst == ((rd & ~msk_v) | (s & msk_v)), "R5", r_dst, (rd & ~msk_v) | (s & msk_v));
                    chk(!r_wrote, "R2", 32'(r_wrote), 32'h0);
                end
            end else begin
                chk(r_accwr && r_acc == ((a & ~msk_v) | (dv & msk_v)), "R3", r_acc, (a & ~msk_v) | (dv & msk_v));
                chk(!r_dstwr && !r_wrote, "R3", {30'b0, r_dstwr, r_wrote}, 32'h0);
            end
        end

        // R6 read fault
        run_op(1, 2'd2, 32'h5, 32'h9, 32'h0, 32'h5, 1, 0, 0);
        chk(r_done && r_abort, "R6", 32'(r_abort), 32'h1);
        chk(!r_accwr && !r_dstwr && !r_flwr && !r_wrote, "R6",
            {28'b0, r_accwr, r_dstwr, r_flwr, r_wrote}, 32'h0);
        chk(r_cyc == 0, "R8", 32'(r_cyc), 32'h0);

        // R7 write fault on matching memory operand
        run_op(1, 2'd1, 32'h0000_4444, 32'h1, 32'h0, 32'hABCD_4444, 0, 1, 0);
        chk(r_done && r_abort, "R7", 32'(r_abort), 32'h1);
        chk(!r_flwr && !r_accwr, "R7", {30'b0, r_flwr, r_accwr}, 32'h0);

        // R10 start pulsed during a pending read is ignored
        run_op(1, 2'd2, 32'h0000_0010, 32'h3, 32'h0, 32'h0000_0020, 0, 0, 1);
        chk(r_done && r_accwr && r_acc == 32'h20, "R10", r_acc, 32'h20);
        chk(r_cyc == 4'd10, "R10", 32'(r_cyc), 32'd10);
        repeat (4) @(negedge clk);
        chk(!busy_o && !done_o, "R10", {30'b0, busy_o, done_o}, 32'h0);

        // R11 request held while acknowledge is withheld
        @(negedge clk);
        start_i = 1; mem_mode_i = 1; size_i = 2'd2; acc_i = 32'h1; src_i = 32'h2;
        @(negedge clk);
        start_i = 0;
        repeat (3) begin
            chk(mem_req_o && !mem_we_o, "R11", {30'b0, mem_req_o, mem_we_o}, 32'h2);
            @(negedge clk);
        end
        mem_ack_i = 1; mem_rdata_i = 32'h1; mem_fault_i = 0;
        @(negedge clk);
        mem_ack_i = 0;
        @(negedge clk);
        chk(mem_req_o && mem_we_o && mem_wdata_o == 32'h2, "R11", mem_wdata_o, 32'h2);
        mem_ack_i = 1;
        @(negedge clk);
        mem_ack_i = 0;
        chk(done_o && !abort_o, "R11", {30'b0, done_o, abort_o}, 32'h2);
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule